// File: doc/BRIEF.md
# ECC Error Capture and Status Unit

This unit sits beside the ECC decoders of a flash controller and records what they report. Each of two memory regions has its own event inputs: the main array (bank 0) and the data EEPROM (bank 1). The inputs are pulses for a corrected single-bit error, an uncorrectable multi-bit error, a decoder malfunction, and a "malfunction check good" result. One access-address bus is shared by both regions. On an event the unit sets a status flag and stores the address of the access that was in progress. It then drives level error lines toward a system error-signalling module.

Software reaches the unit through a small register port. It reads the status flags and the two captured addresses per bank, and it clears flags by writing 1. Correctable errors form one capture group per bank, with their own address register. Uncorrectable errors and malfunctions form a second group, which shares the uncorrectable address register. After a capture, a group freezes its flags and its address. It re-arms only when both of these have happened, in either order: its flags have been cleared, and its address register has been read. An error handler that skips either step loses every later event on that group.

A diagnostic-mode input enables the "malfunction check good" flag. Outside diagnostic mode that flag stays at zero. Injected malfunction events take exactly the same capture path as real ones.

Top module: `ecc_fault_logger`

## Requirements
- R1: A malfunction event on an armed uncorrectable group sets status bit 2 of that bank and stores `acc_addr_i` in the bank's uncorrectable address register (select 2).
- R2: A correctable event sets status bit 0 and stores the address in the correctable address register (select 1). An uncorrectable event sets status bit 1 and stores the address in select 2. The two groups capture independently, even when both fire in the same cycle.
- R3: After a capture, the group ignores further events: its flags gain no new bits and its address holds. This lasts until its flags have been cleared and its address register has been read, in either order. Events are accepted from the cycle after the later of those two register accesses.
- R4: `err_main_unc_o` is the OR of bank 0 status bits 1 and 2. `err_ee_unc_o` is bank 1 status bit 1. `err_ee_mal_o` is bank 1 status bit 2. `err_corr_o` is the OR of status bit 0 of both banks. Each line is a level that falls when its flags are cleared.
- R5: Status bit 3 ("malfunction check good") is set by its event only while `diag_en_i` is 1. It is forced to 0 whenever `diag_en_i` is 0, and it stays 0 when diagnostic mode returns.
- R6: Malfunction events raised while `diag_en_i` is 1 are captured exactly as in R1.
- R7: Writing a status register clears each flag whose data bit is 1. Data bits at 0 leave flags unchanged. Writes to address registers have no effect.
- R8: An event that arrives in the same cycle as the re-arming register access is dropped. An event in the next cycle is captured.
- R9: The register index is {bank, select[1:0]}. Select 0 is status, 1 is the correctable address, 2 is the uncorrectable address, and 3 reads 0. Read data appears on `reg_rdata_o` one cycle after `reg_rd_i`, zero-extended.
- R10: After reset, every flag and address reads 0, all error lines are low, and every group is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| diag_en_i | input | 1 | Diagnostic mode enable |
| acc_addr_i | input | ADDR_W | Address of the current access |
| sec_evt_i | input | 2 | Correctable error pulse, one per bank |
| ded_evt_i | input | 2 | Uncorrectable error pulse, one per bank |
| mal_evt_i | input | 2 | Decoder malfunction pulse, one per bank |
| mg_evt_i | input | 2 | Malfunction check good pulse, one per bank |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index {bank, select} |
| reg_wdata_i | input | DATA_W | Write data (write 1 to clear) |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| err_corr_o | output | 1 | Any correctable flag pending |
| err_main_unc_o | output | 1 | Main-array uncorrectable or malfunction flag pending |
| err_ee_unc_o | output | 1 | EEPROM uncorrectable flag pending |
| err_ee_mal_o | output | 1 | EEPROM malfunction flag pending |

## Verification
Some properties are checked on every cycle:
- A capture loads the access address.
- A frozen group neither changes its address nor gains a flag.
- Re-arming is always preceded by a read of the address.
- The diagnostic-only flag is clear outside diagnostic mode.
- A rising EEPROM malfunction line always follows an EEPROM malfunction event.
- The spare register slot reads 0.

Other behaviour can only be shown by the bench scenarios. These cover the full two-step re-arm handshake in both orders, the event that is dropped on the re-arming cycle, the write-0 and address-write cases that must have no effect, and the mapping of each bank and event kind onto the four error lines.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int NBANK     = 2;
    localparam int BANK_MAIN = 0;
    localparam int BANK_EE   = 1;
    localparam int BANK_W    = $clog2(NBANK);
    localparam int SEL_W     = 2;
    localparam int REG_AW    = BANK_W + SEL_W;

    localparam logic [SEL_W-1:0] SEL_STAT  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CADDR = 2'd1;
    localparam logic [SEL_W-1:0] SEL_UADDR = 2'd2;
    localparam logic [SEL_W-1:0] SEL_RSVD  = 2'd3;

    localparam int STAT_W   = 4;
    localparam int STAT_COR = 0;
    localparam int STAT_UNC = 1;
    localparam int STAT_MAL = 2;
    localparam int STAT_MG  = 3;
endpackage

// File: rtl/ecc_cap_group.sv
module ecc_cap_group #(
    parameter int ADDR_W = 16,
    parameter int NFLAG  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NFLAG-1:0]  evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NFLAG-1:0]  clr_i,
    input  logic              addr_rd_i,
    output logic [NFLAG-1:0]  flags_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [NFLAG-1:0]  flags;
        logic [ADDR_W-1:0] addr;
        logic              armed;
        logic              clr_seen;
        logic              rd_seen;
    } grp_t;

    grp_t s_q, s_d;
    logic             cap;
    logic [NFLAG-1:0] left;
    logic             clr_ok;
    logic             rd_ok;

    always_comb begin
        s_d    = s_q;
        cap    = s_q.armed && (|evt_i);
        left   = s_q.flags & ~clr_i;
        clr_ok = 1'b0;
        rd_ok  = 1'b0;
        s_d.flags = left;
        if (cap) begin
            s_d.flags    = left | evt_i;
            s_d.addr     = addr_i;
            s_d.armed    = 1'b0;
            s_d.clr_seen = 1'b0;
            s_d.rd_seen  = 1'b0;
        end else if (!s_q.armed) begin
            clr_ok = s_q.clr_seen || ((|clr_i) && (left == '0));
            rd_ok  = s_q.rd_seen || addr_rd_i;
            s_d.clr_seen = clr_ok;
            s_d.rd_seen  = rd_ok;
            if (clr_ok && rd_ok) begin
                s_d.armed    = 1'b1;
                s_d.clr_seen = 1'b0;
                s_d.rd_seen  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.flags    <= '0;
            s_q.addr     <= '0;
            s_q.armed    <= 1'b1;
            s_q.clr_seen <= 1'b0;
            s_q.rd_seen  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_o = s_q.flags;
    assign addr_o  = s_q.addr;

    AST_CAPTURE_TAKES_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.armed && (|evt_i)) |=> (s_q.addr == $past(addr_i)) && !s_q.armed); // R1 R2
    AST_FROZEN_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.armed |=> $stable(s_q.addr)); // R3
    AST_FROZEN_NO_NEW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.armed |=> ((s_q.flags & ~$past(s_q.flags)) == '0)); // R3
    AST_REARM_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.armed) |-> ($past(addr_rd_i) || $past(s_q.rd_seen))); // R3
endmodule

// File: rtl/ecc_cap_bank.sv
module ecc_cap_bank
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              diag_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sec_evt_i,
    input  logic              ded_evt_i,
    input  logic              mal_evt_i,
    input  logic              mg_evt_i,
    input  logic              wr_stat_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              rd_caddr_i,
    input  logic              rd_uaddr_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [ADDR_W-1:0] caddr_o,
    output logic [ADDR_W-1:0] uaddr_o
);
    typedef struct packed {
        logic mg;
    } mg_t;

    mg_t        m_q, m_d;
    logic [0:0] cor_flag;
    logic [1:0] unc_flags;
    logic [0:0] cor_clr;
    logic [1:0] unc_clr;

    assign cor_clr = {wr_stat_i & wdata_i[STAT_COR]};
    assign unc_clr = {wr_stat_i & wdata_i[STAT_MAL], wr_stat_i & wdata_i[STAT_UNC]};

    ecc_cap_group #(.ADDR_W(ADDR_W), .NFLAG(1)) u_cor (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (sec_evt_i),
        .addr_i    (addr_i),
        .clr_i     (cor_clr),
        .addr_rd_i (rd_caddr_i),
        .flags_o   (cor_flag),
        .addr_o    (caddr_o)
    );

    ecc_cap_group #(.ADDR_W(ADDR_W), .NFLAG(2)) u_unc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     ({mal_evt_i, ded_evt_i}),
        .addr_i    (addr_i),
        .clr_i     (unc_clr),
        .addr_rd_i (rd_uaddr_i),
        .flags_o   (unc_flags),
        .addr_o    (uaddr_o)
    );

    always_comb begin
        m_d = m_q;
        if (!diag_en_i) begin
            m_d.mg = 1'b0;
        end else begin
            m_d.mg = (m_q.mg & ~(wr_stat_i & wdata_i[STAT_MG])) | mg_evt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q.mg <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign stat_o = {m_q.mg, unc_flags[1], unc_flags[0], cor_flag[0]};

    AST_MG_ZERO_OUTSIDE_DIAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !diag_en_i |=> !stat_o[STAT_MG]); // R5
endmodule

// File: rtl/ecc_fault_logger.sv
module ecc_fault_logger
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              diag_en_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [NBANK-1:0]  sec_evt_i,
    input  logic [NBANK-1:0]  ded_evt_i,
    input  logic [NBANK-1:0]  mal_evt_i,
    input  logic [NBANK-1:0]  mg_evt_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              err_corr_o,
    output logic              err_main_unc_o,
    output logic              err_ee_unc_o,
    output logic              err_ee_mal_o
);
    localparam int AZ = DATA_W - ADDR_W;
    localparam int SZ = DATA_W - STAT_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t               r_q, r_d;
    logic [BANK_W-1:0] bsel;
    logic [SEL_W-1:0]  rsel;
    logic [STAT_W-1:0] stat  [NBANK];
    logic [ADDR_W-1:0] caddr [NBANK];
    logic [ADDR_W-1:0] uaddr [NBANK];
    logic [NBANK-1:0]  cor_any;
    logic              unused_wdata;

    assign bsel         = reg_addr_i[REG_AW-1:SEL_W];
    assign rsel         = reg_addr_i[SEL_W-1:0];
    assign unused_wdata = ^reg_wdata_i[DATA_W-1:STAT_W];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit;
        assign hit = (bsel == BANK_W'(g));
        ecc_cap_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .diag_en_i  (diag_en_i),
            .addr_i     (acc_addr_i),
            .sec_evt_i  (sec_evt_i[g]),
            .ded_evt_i  (ded_evt_i[g]),
            .mal_evt_i  (mal_evt_i[g]),
            .mg_evt_i   (mg_evt_i[g]),
            .wr_stat_i  (reg_wr_i && hit && (rsel == SEL_STAT)),
            .wdata_i    (reg_wdata_i[STAT_W-1:0]),
            .rd_caddr_i (reg_rd_i && hit && (rsel == SEL_CADDR)),
            .rd_uaddr_i (reg_rd_i && hit && (rsel == SEL_UADDR)),
            .stat_o     (stat[g]),
            .caddr_o    (caddr[g]),
            .uaddr_o    (uaddr[g])
        );
        assign cor_any[g] = stat[g][STAT_COR];
    end

    always_comb begin
        r_d = r_q;
        if (reg_rd_i) begin
            case (rsel)
                SEL_STAT:  r_d.rdata = {{SZ{1'b0}}, stat[bsel]};
                SEL_CADDR: r_d.rdata = {{AZ{1'b0}}, caddr[bsel]};
                SEL_UADDR: r_d.rdata = {{AZ{1'b0}}, uaddr[bsel]};
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata_o    = r_q.rdata;
    assign err_corr_o     = |cor_any;
    assign err_main_unc_o = stat[BANK_MAIN][STAT_UNC] | stat[BANK_MAIN][STAT_MAL];
    assign err_ee_unc_o   = stat[BANK_EE][STAT_UNC];
    assign err_ee_mal_o   = stat[BANK_EE][STAT_MAL];

    AST_EE_MAL_FROM_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_ee_mal_o) |-> $past(mal_evt_i[BANK_EE])); // R4
    AST_RSVD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && (rsel == SEL_RSVD)) |=> (reg_rdata_o == '0)); // R9
endmodule

// File: tb/tb_ecc_fault_logger.sv
module tb_ecc_fault_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        diag = 1'b0;
    logic [15:0] acc = '0;
    logic [1:0]  sec = '0, ded = '0, mal = '0, mg = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [2:0]  ra = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdat;
    logic        e_cor, e_mu, e_eu, e_em;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    ecc_fault_logger dut (
        .clk_i(clk), .rst_ni(rst_n), .diag_en_i(diag), .acc_addr_i(acc),
        .sec_evt_i(sec), .ded_evt_i(ded), .mal_evt_i(mal), .mg_evt_i(mg),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(ra), .reg_wdata_i(wd),
        .reg_rdata_o(rdat), .err_corr_o(e_cor), .err_main_unc_o(e_mu),
        .err_ee_unc_o(e_eu), .err_ee_mal_o(e_em)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rreg(input int b, input int s, output logic [31:0] d);
        rd = 1'b1; ra = 3'(b * 4 + s);
        @(negedge clk);
        d = rdat; rd = 1'b0;
    endtask

    task automatic wreg(input int b, input int s, input logic [31:0] d);
        wr = 1'b1; ra = 3'(b * 4 + s); wd = d;
        @(negedge clk);
        wr = 1'b0; wd = '0;
    endtask

    task automatic evt(input int b, input int k, input logic [15:0] a);
        acc = a;
        case (k)
            0: sec[b] = 1'b1;
            1: ded[b] = 1'b1;
            default: mal[b] = 1'b1;
        endcase
        @(negedge clk);
        sec = '0; ded = '0; mal = '0;
    endtask

    function automatic logic [3:0] lines(input int b, input int k);
        lines = {k == 0, (b == 0) && (k > 0), (b == 1) && (k == 1), (b == 1) && (k == 2)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] a1, a2, a3;
        int          sel;
        logic [31:0] bit_k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 / R9: reset state, reserved slot reads zero
        for (int r = 0; r < 8; r++) begin
            rreg(r / 4, r % 4, d);
            chk("R10 reset register", d, 32'h0);
        end
        chk("R10 reset lines", {28'h0, e_cor, e_mu, e_eu, e_em}, 32'h0);

        // R1 R2 R3 R4 R7: sweep over bank, kind and addresses
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 3; k++) begin
                for (int i = 0; i < 3; i++) begin
                    a1 = 16'(16'h1000 * (k + 1) + b * 16'h0101 + i * 37);
                    a2 = a1 ^ 16'h5a5a;
                    a3 = a1 + 16'h0777;
                    sel = (k == 0) ? 1 : 2;
                    bit_k = 32'(1) << k;
                    evt(b, k, a1);
                    rreg(b, 0, d);
                    chk("R1 R2 flag set", d, bit_k);
                    chk("R4 line high", {28'h0, e_cor, e_mu, e_eu, e_em}, {28'h0, lines(b, k)});
                    // frozen: a second event of the group is ignored
                    evt(b, (k == 0) ? 0 : 3 - k, a2);
                    rreg(b, 0, d);
                    chk("R3 frozen no new flag", d, bit_k);
                    wreg(b, 0, 32'h0);
                    rreg(b, 0, d);
                    chk("R7 write 0 no effect", d, bit_k);
                    wreg(b, sel, 32'hffff);
                    wreg(b, 0, bit_k);
                    rreg(b, 0, d);
                    chk("R7 W1C clears", d, 32'h0);
                    chk("R4 line falls", {28'h0, e_cor, e_mu, e_eu, e_em}, 32'h0);
                    evt(b, k, a2);
                    rreg(b, 0, d);
                    chk("R3 cleared but not read: dropped", d, 32'h0);
                    rreg(b, sel, d);
                    chk("R1 R2 R3 R7 address held", d, {16'h0, a1});
                    evt(b, k, a3);
                    rreg(b, sel, d);
                    chk("R3 rearmed capture", d, {16'h0, a3});
                    rreg(b, 0, d);
                    chk("R3 rearmed flag", d, bit_k);
                    wreg(b, 0, bit_k);
                    rreg(b, 0, d);
                    chk("R3 read-then-clear", d, 32'h0);
                end
            end
        end

        // R2: both groups in one cycle, same address
        acc = 16'hbeef; sec[0] = 1'b1; ded[0] = 1'b1;
        @(negedge clk);
        sec = '0; ded = '0;
        rreg(0, 0, d); chk("R2 both flags", d, 32'h3);
        rreg(0, 1, d); chk("R2 correctable address", d, 32'hbeef);
        rreg(0, 2, d); chk("R2 uncorrectable address", d, 32'hbeef);
        rreg(0, 3, d); chk("R9 reserved zero", d, 32'h0);
        chk("R4 both lines", {28'h0, e_cor, e_mu, e_eu, e_em}, 32'hc);
        wreg(0, 0, 32'h3);

        // R6: injected malfunction in diagnostic mode
        diag = 1'b1;
        evt(1, 2, 16'h0abc);
        rreg(1, 0, d); chk("R6 injected malfunction flag", d, 32'h4);
        rreg(1, 2, d); chk("R6 injected malfunction address", d, 32'h0abc);
        chk("R6 ee malfunction line", {31'h0, e_em}, 32'h1);
        wreg(1, 0, 32'h4);
        chk("R4 ee malfunction line falls", {31'h0, e_em}, 32'h0);

        // R5: check-good flag only in diagnostic mode
        diag = 1'b0;
        mg[0] = 1'b1; @(negedge clk); mg = '0;
        rreg(0, 0, d); chk("R5 outside diag stays 0", d, 32'h0);
        diag = 1'b1;
        mg[0] = 1'b1; @(negedge clk); mg = '0;
        rreg(0, 0, d); chk("R5 set in diag", d, 32'h8);
        wreg(0, 0, 32'h7);
        rreg(0, 0, d); chk("R7 other bits leave check-good", d, 32'h8);
        diag = 1'b0; @(negedge clk);
        rreg(0, 0, d); chk("R5 forced 0 when diag off", d, 32'h0);
        diag = 1'b1; @(negedge clk);
        rreg(0, 0, d); chk("R5 stays 0 on return", d, 32'h0);
        diag = 1'b0;

        // R8: event on the re-arming read cycle is dropped
        evt(1, 0, 16'h1111);
        wreg(1, 0, 32'h1);
        rd = 1'b1; ra = 3'(4 + 1); acc = 16'h2222; sec[1] = 1'b1;
        @(negedge clk);
        d = rdat; rd = 1'b0; sec = '0;
        chk("R8 read returns old address", d, 32'h1111);
        rreg(1, 0, d); chk("R8 same-cycle event dropped", d, 32'h0);
        evt(1, 0, 16'h3333);
        rreg(1, 1, d); chk("R8 next event captured", d, 32'h3333);
        rreg(1, 0, d); chk("R8 next event flag", d, 32'h1);
        chk("R4 corr line", {31'h0, e_cor}, 32'h1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule